// File: doc/BRIEF.md
# Preemptive DMA Channel Scheduler

This block serves a set of DMA channels, each of which raises a transfer request from any of three trigger inputs. A fixed-priority picker chooses one channel at a time to be active. The scheduler then reads that channel's four-word transfer descriptor through a dedicated fetch port into local working registers. After that it copies memory to memory one 32-bit word at a time: each word is read on the data read channel and written on the data write channel.

Between beats the scheduler checks for a pending channel with a lower index. If one is found, it saves the partly consumed descriptor through a separate write-back port and releases the active channel. The saved channel stays pending. When it is granted again, its descriptor is fetched from the write-back area and the copy resumes where it stopped. A descriptor may name a follow-on descriptor, which builds multi-buffer chains, or name itself, which builds a circular buffer. A per-channel enable gates a one-cycle completion pulse raised at the end of the chain.

Top module: `dma_sched`

## Requirements
- R1: A one-cycle pulse on any of `sw_trig[n]`, `evt_trig[n]` or `per_req[n]` marks channel n pending. The channel stays pending until its descriptor chain ends, including across preemption.
- R2: While no channel is active, the pending channel with the lowest index is granted. `act_valid` goes high and `act_ch` shows that index.
- R3: After a fresh grant the four descriptor words are read in the order count, source, destination, next. They are read from `DESC_BASE + 16*n + 4*k`, where k is the word index 0 to 3. No data beat is issued until all four words have arrived.
- R4: Each beat reads one word at the current source address and writes the same word to the current destination address. Both addresses then advance by 4 and the remaining count drops by one.
- R5: A descriptor carries exactly `count` beats. A count of zero produces no beat.
- R6: If a lower-index channel is pending at a beat boundary, the active channel's count, source, destination and next words are written, in that order, to `WB_BASE + 16*n + 4*k`. The lower-index channel is then granted.
- R7: A preempted channel later fetches its descriptor from `WB_BASE + 16*n` and finishes the remaining beats with the saved addresses.
- R8: When a descriptor's count is used up and its next word is non-zero, the descriptor at that address is fetched and executed. A next word of zero ends the chain, and a self-link repeats the same descriptor without end.
- R9: At the end of a chain, `done_pulse[n]` is high for exactly one cycle if `done_en[n]` is set, and stays low otherwise. A chain ends once; ending a block that links onward gives no pulse.
- R10: Only one request valid among fetch, data read, data write and write-back is high at a time. A valid that is not accepted keeps its address until `ready`.
- R11: Synchronous reset clears all pending state and the active channel, and leaves every valid and every completion pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_trig | input | NUM_CH | Software trigger pulse per channel |
| evt_trig | input | NUM_CH | Event trigger pulse per channel |
| per_req | input | NUM_CH | Peripheral request pulse per channel |
| done_en | input | NUM_CH | Per-channel completion pulse enable |
| done_pulse | output | NUM_CH | One-cycle end-of-chain pulse |
| act_valid | output | 1 | A channel is active |
| act_ch | output | CH_W | Index of the active channel |
| fch_valid | output | 1 | Descriptor read request |
| fch_addr | output | AW | Descriptor read address |
| fch_ready | input | 1 | Descriptor read accepted |
| fch_rvalid | input | 1 | Descriptor read data valid |
| fch_rdata | input | DW | Descriptor read data |
| dat_rd_valid | output | 1 | Data read request |
| dat_rd_addr | output | AW | Data read address |
| dat_rd_ready | input | 1 | Data read accepted |
| dat_rvalid | input | 1 | Data read data valid |
| dat_rdata | input | DW | Data read data |
| dat_wr_valid | output | 1 | Data write request |
| dat_wr_addr | output | AW | Data write address |
| dat_wr_data | output | DW | Data write data |
| dat_wr_ready | input | 1 | Data write accepted |
| wb_valid | output | 1 | Descriptor write-back request |
| wb_addr | output | AW | Write-back address |
| wb_data | output | DW | Write-back data |
| wb_ready | input | 1 | Write-back accepted |

## Verification
The assertions assume that each read port returns exactly one `rvalid` for each accepted request, one cycle or more after acceptance and never unprompted. They also assume that `done_en` does not change while a chain is finishing. The bench memory model replies to every accepted read exactly one cycle later and holds the enables steady for the whole of each scenario. In one scenario the model withholds the ready signals in a pseudo-random pattern, so that request holding is exercised without breaking the one-reply-per-request rule.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FRSP,
    ST_DECIDE,
    ST_RREQ,
    ST_RRSP,
    ST_WR,
    ST_WB
  } eng_state_t;

  localparam int DESC_WORDS = 4;
  localparam int SLOT_SHIFT = 4;
  localparam int WORD_SHIFT = 2;

endpackage

// File: rtl/dma_pend_bank.sv
module dma_pend_bank #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic [NUM_CH-1:0] evt_trig,
  input  logic [NUM_CH-1:0] per_req,
  input  logic [NUM_CH-1:0] done_en,
  input  logic              fin,
  input  logic              park,
  input  logic [CH_W-1:0]   cur_ch,
  output logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] susp,
  output logic [NUM_CH-1:0] done_pulse
);

  logic [NUM_CH-1:0] sel;
  logic [NUM_CH-1:0] trig_any;

  genvar gn;
  generate
    for (gn = 0; gn < NUM_CH; gn++) begin : g_sel
      assign sel[gn]      = (cur_ch == CH_W'(gn));
      assign trig_any[gn] = sw_trig[gn] | evt_trig[gn] | per_req[gn];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      susp       <= '0;
      done_pulse <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        pend[i]       <= (pend[i] & ~(fin & sel[i])) | trig_any[i];
        done_pulse[i] <= fin & sel[i] & done_en[i];
        if (park && sel[i])
          susp[i] <= 1'b1;
        else if (fin && sel[i])
          susp[i] <= 1'b0;
      end
    end
  end

  // R9: completion pulses never overlap and never last two cycles
  assert_done_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_pulse));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    (|done_pulse) |=> !(|done_pulse));

endmodule

// File: rtl/dma_prio_enc.sv
module dma_prio_enc #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CH_W-1:0]   act_ch,
  output logic              any,
  output logic [CH_W-1:0]   idx,
  output logic              hi_pend
);

  logic [NUM_CH-1:0] below;

  genvar gb;
  generate
    for (gb = 0; gb < NUM_CH; gb++) begin : g_below
      assign below[gb] = req[gb] & (CH_W'(gb) < act_ch);
    end
  endgenerate

  assign hi_pend = |below;
  assign any     = |req;

  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) idx = CH_W'(i);
    end
  end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_sched_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter int          CH_W      = 2,
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CNT_W     = 16,
  parameter logic [31:0] DESC_BASE = 32'h0000_0100,
  parameter logic [31:0] WB_BASE   = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant_any,
  input  logic [CH_W-1:0]   grant_idx,
  input  logic              hi_pend,
  input  logic [NUM_CH-1:0] susp,
  output logic              act_valid,
  output logic [CH_W-1:0]   act_ch,
  output logic              fin,
  output logic              park,
  output logic              fch_valid,
  output logic [AW-1:0]     fch_addr,
  input  logic              fch_ready,
  input  logic              fch_rvalid,
  input  logic [DW-1:0]     fch_rdata,
  output logic              dat_rd_valid,
  output logic [AW-1:0]     dat_rd_addr,
  input  logic              dat_rd_ready,
  input  logic              dat_rvalid,
  input  logic [DW-1:0]     dat_rdata,
  output logic              dat_wr_valid,
  output logic [AW-1:0]     dat_wr_addr,
  output logic [DW-1:0]     dat_wr_data,
  input  logic              dat_wr_ready,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_addr,
  output logic [DW-1:0]     wb_data,
  input  logic              wb_ready
);

  localparam logic [AW-1:0] STEP      = AW'(DW / 8);
  localparam logic [AW-1:0] FBASE     = AW'(DESC_BASE);
  localparam logic [AW-1:0] SBASE     = AW'(WB_BASE);
  localparam int            KW        = $clog2(DESC_WORDS);
  localparam logic [KW-1:0] K_LAST    = KW'(DESC_WORDS - 1);

  eng_state_t        state;
  logic [CH_W-1:0]   ch;
  logic [KW-1:0]     k;
  logic [AW-1:0]     fptr;
  logic [CNT_W-1:0]  cnt;
  logic [AW-1:0]     src;
  logic [AW-1:0]     dst;
  logic [AW-1:0]     nxt;
  logic [DW-1:0]     beat_q;
  logic [AW-1:0]     grant_off;
  logic [AW-1:0]     cur_off;
  logic [AW-1:0]     word_off;

  assign grant_off = AW'({grant_idx, {SLOT_SHIFT{1'b0}}});
  assign cur_off   = AW'({ch, {SLOT_SHIFT{1'b0}}});
  assign word_off  = AW'({k, {WORD_SHIFT{1'b0}}});

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ch     <= '0;
      k      <= '0;
      fptr   <= '0;
      cnt    <= '0;
      src    <= '0;
      dst    <= '0;
      nxt    <= '0;
      beat_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (grant_any) begin
            ch    <= grant_idx;
            k     <= '0;
            fptr  <= (susp[grant_idx] ? SBASE : FBASE) + grant_off;
            state <= ST_FREQ;
          end
        end
        ST_FREQ: begin
          if (fch_ready) state <= ST_FRSP;
        end
        ST_FRSP: begin
          if (fch_rvalid) begin
            case (k)
              KW'(0):  cnt <= fch_rdata[CNT_W-1:0];
              KW'(1):  src <= fch_rdata[AW-1:0];
              KW'(2):  dst <= fch_rdata[AW-1:0];
              default: nxt <= fch_rdata[AW-1:0];
            endcase
            if (k == K_LAST) begin
              k     <= '0;
              state <= ST_DECIDE;
            end else begin
              k     <= k + KW'(1);
              state <= ST_FREQ;
            end
          end
        end
        ST_DECIDE: begin
          if (cnt == '0) begin
            if (nxt != '0) begin
              fptr  <= nxt;
              k     <= '0;
              state <= ST_FREQ;
            end else begin
              state <= ST_IDLE;
            end
          end else if (hi_pend) begin
            k     <= '0;
            state <= ST_WB;
          end else begin
            state <= ST_RREQ;
          end
        end
        ST_RREQ: begin
          if (dat_rd_ready) state <= ST_RRSP;
        end
        ST_RRSP: begin
          if (dat_rvalid) begin
            beat_q <= dat_rdata;
            state  <= ST_WR;
          end
        end
        ST_WR: begin
          if (dat_wr_ready) begin
            cnt   <= cnt - CNT_W'(1);
            src   <= src + STEP;
            dst   <= dst + STEP;
            state <= ST_DECIDE;
          end
        end
        ST_WB: begin
          if (wb_ready) begin
            if (k == K_LAST) state <= ST_IDLE;
            else             k     <= k + KW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign act_valid    = (state != ST_IDLE);
  assign act_ch       = ch;
  assign fin          = (state == ST_DECIDE) && (cnt == '0) && (nxt == '0);
  assign park         = (state == ST_WB) && wb_ready && (k == K_LAST);

  assign fch_valid    = (state == ST_FREQ);
  assign fch_addr     = fptr + word_off;
  assign dat_rd_valid = (state == ST_RREQ);
  assign dat_rd_addr  = src;
  assign dat_wr_valid = (state == ST_WR);
  assign dat_wr_addr  = dst;
  assign dat_wr_data  = beat_q;
  assign wb_valid     = (state == ST_WB);
  assign wb_addr      = SBASE + cur_off + word_off;

  always_comb begin
    case (k)
      KW'(0):  wb_data = DW'(cnt);
      KW'(1):  wb_data = DW'(src);
      KW'(2):  wb_data = DW'(dst);
      default: wb_data = DW'(nxt);
    endcase
  end

  // R10: one request at a time, held with a stable address until accepted
  assert_one_port_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fch_valid, dat_rd_valid, dat_wr_valid, wb_valid}));
  assert_fch_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (fch_valid && !fch_ready) |=> (fch_valid && $stable(fch_addr)));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (dat_rd_valid && !dat_rd_ready) |=> (dat_rd_valid && $stable(dat_rd_addr)));
  // R4: a data write only starts after a read reply came back
  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_wr_valid) |-> $past(dat_rvalid));

endmodule

// File: rtl/dma_sched.sv
module dma_sched #(
  parameter int          NUM_CH    = 4,
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CNT_W     = 16,
  parameter logic [31:0] DESC_BASE = 32'h0000_0100,
  parameter logic [31:0] WB_BASE   = 32'h0000_0200,
  localparam int         CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic [NUM_CH-1:0] evt_trig,
  input  logic [NUM_CH-1:0] per_req,
  input  logic [NUM_CH-1:0] done_en,
  output logic [NUM_CH-1:0] done_pulse,
  output logic              act_valid,
  output logic [CH_W-1:0]   act_ch,
  output logic              fch_valid,
  output logic [AW-1:0]     fch_addr,
  input  logic              fch_ready,
  input  logic              fch_rvalid,
  input  logic [DW-1:0]     fch_rdata,
  output logic              dat_rd_valid,
  output logic [AW-1:0]     dat_rd_addr,
  input  logic              dat_rd_ready,
  input  logic              dat_rvalid,
  input  logic [DW-1:0]     dat_rdata,
  output logic              dat_wr_valid,
  output logic [AW-1:0]     dat_wr_addr,
  output logic [DW-1:0]     dat_wr_data,
  input  logic              dat_wr_ready,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_addr,
  output logic [DW-1:0]     wb_data,
  input  logic              wb_ready
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] susp;
  logic              grant_any;
  logic [CH_W-1:0]   grant_idx;
  logic              hi_pend;
  logic              fin;
  logic              park;

  dma_pend_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .sw_trig    (sw_trig),
    .evt_trig   (evt_trig),
    .per_req    (per_req),
    .done_en    (done_en),
    .fin        (fin),
    .park       (park),
    .cur_ch     (act_ch),
    .pend       (pend),
    .susp       (susp),
    .done_pulse (done_pulse)
  );

  dma_prio_enc #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_prio (
    .req     (pend),
    .act_ch  (act_ch),
    .any     (grant_any),
    .idx     (grant_idx),
    .hi_pend (hi_pend)
  );

  dma_xfer_engine #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW), .DW(DW), .CNT_W(CNT_W),
    .DESC_BASE(DESC_BASE), .WB_BASE(WB_BASE)
  ) u_eng (
    .clk          (clk),
    .rst          (rst),
    .grant_any    (grant_any),
    .grant_idx    (grant_idx),
    .hi_pend      (hi_pend),
    .susp         (susp),
    .act_valid    (act_valid),
    .act_ch       (act_ch),
    .fin          (fin),
    .park         (park),
    .fch_valid    (fch_valid),
    .fch_addr     (fch_addr),
    .fch_ready    (fch_ready),
    .fch_rvalid   (fch_rvalid),
    .fch_rdata    (fch_rdata),
    .dat_rd_valid (dat_rd_valid),
    .dat_rd_addr  (dat_rd_addr),
    .dat_rd_ready (dat_rd_ready),
    .dat_rvalid   (dat_rvalid),
    .dat_rdata    (dat_rdata),
    .dat_wr_valid (dat_wr_valid),
    .dat_wr_addr  (dat_wr_addr),
    .dat_wr_data  (dat_wr_data),
    .dat_wr_ready (dat_wr_ready),
    .wb_valid     (wb_valid),
    .wb_addr      (wb_addr),
    .wb_data      (wb_data),
    .wb_ready     (wb_ready)
  );

  // R6: a save only happens while a lower-index channel is still waiting
  assert_wb_has_winner_R6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> hi_pend);
  // R1: the active channel stays pending until its chain ends
  assert_active_pending_R1: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !$rose(act_valid)) |-> pend[act_ch]);

endmodule

// File: tb/dma_sched_bench.sv
`timescale 1ns/1ps
module dma_sched_bench;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] sw_trig = '0, evt_trig = '0, per_req = '0, done_en = '0;
  logic [NCH-1:0] done_pulse;
  logic act_valid;
  logic [1:0] act_ch;
  logic fch_valid, dat_rd_valid, dat_wr_valid, wb_valid;
  logic [31:0] fch_addr, dat_rd_addr, dat_wr_addr, dat_wr_data, wb_addr, wb_data;
  logic fch_ready = 1'b1, dat_rd_ready = 1'b1, dat_wr_ready = 1'b1, wb_ready = 1'b1;
  logic fch_rvalid = 1'b0, dat_rvalid = 1'b0;
  logic [31:0] fch_rdata = '0, dat_rdata = '0;

  initial forever #2.5 clk = ~clk;

  dma_sched #(.NUM_CH(NCH)) u_dma_sched (
    .clk(clk), .rst(rst), .sw_trig(sw_trig), .evt_trig(evt_trig), .per_req(per_req),
    .done_en(done_en), .done_pulse(done_pulse), .act_valid(act_valid), .act_ch(act_ch),
    .fch_valid(fch_valid), .fch_addr(fch_addr), .fch_ready(fch_ready),
    .fch_rvalid(fch_rvalid), .fch_rdata(fch_rdata),
    .dat_rd_valid(dat_rd_valid), .dat_rd_addr(dat_rd_addr), .dat_rd_ready(dat_rd_ready),
    .dat_rvalid(dat_rvalid), .dat_rdata(dat_rdata),
    .dat_wr_valid(dat_wr_valid), .dat_wr_addr(dat_wr_addr), .dat_wr_data(dat_wr_data),
    .dat_wr_ready(dat_wr_ready),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(wb_ready)
  );

  logic [31:0] mem [1024];
  int checks = 0, fails = 0;
  int wr_cnt = 0, fch_cnt = 0, cyc = 0, proto_err = 0, rd_before_fetch = -1;
  int done_cnt [NCH];
  int done_cyc [NCH];
  logic [31:0] flog [8];
  bit stall = 1'b0, seen_wb_fetch = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic pf_v = 1'b0, pf_r = 1'b0, pd_v = 1'b0, pd_r = 1'b0;
  logic [31:0] pf_a = '0, pd_a = '0;

  // memory model and monitors, reacting to values present before each edge
  initial begin
    for (int i = 0; i < NCH; i++) begin done_cnt[i] = 0; done_cyc[i] = 0; end
    forever begin
      @(posedge clk);
      cyc++;
      if (!rst) begin
        if (pf_v && !pf_r && !(fch_valid && fch_addr == pf_a)) proto_err++;
        if (pd_v && !pd_r && !(dat_rd_valid && dat_rd_addr == pd_a)) proto_err++;
        if ((int'(fch_valid) + int'(dat_rd_valid) + int'(dat_wr_valid) + int'(wb_valid)) > 1)
          proto_err++;
      end
      pf_v = fch_valid; pf_r = fch_ready; pf_a = fch_addr;
      pd_v = dat_rd_valid; pd_r = dat_rd_ready; pd_a = dat_rd_addr;
      if (fch_valid && fch_ready) begin
        fch_rvalid <= 1'b1;
        fch_rdata  <= mem[fch_addr[11:2]];
        if (fch_cnt < 8) flog[fch_cnt] = fch_addr;
        fch_cnt++;
        if (fch_addr == 32'h230) seen_wb_fetch = 1'b1;
      end else fch_rvalid <= 1'b0;
      if (dat_rd_valid && dat_rd_ready) begin
        dat_rvalid <= 1'b1;
        dat_rdata  <= mem[dat_rd_addr[11:2]];
        if (rd_before_fetch < 0) rd_before_fetch = fch_cnt;
      end else dat_rvalid <= 1'b0;
      if (dat_wr_valid && dat_wr_ready) begin
        mem[dat_wr_addr[11:2]] = dat_wr_data;
        wr_cnt++;
      end
      if (wb_valid && wb_ready) mem[wb_addr[11:2]] = wb_data;
      for (int i = 0; i < NCH; i++)
        if (done_pulse[i]) begin done_cnt[i]++; done_cyc[i] = cyc; end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (stall) begin
        fch_ready <= lfsr[0]; dat_rd_ready <= lfsr[3];
        dat_wr_ready <= lfsr[6]; wb_ready <= lfsr[9];
      end else begin
        fch_ready <= 1'b1; dat_rd_ready <= 1'b1; dat_wr_ready <= 1'b1; wb_ready <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n);
    mem[a[11:2]] = c; mem[a[11:2] + 1] = s; mem[a[11:2] + 2] = d; mem[a[11:2] + 3] = n;
  endtask

  task automatic fill(input logic [31:0] s, input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      mem[s[11:2] + 10'(i)] = 32'hA500_0000 + s + 32'(4 * i);
      mem[d[11:2] + 10'(i)] = 32'h0;
    end
  endtask

  function automatic int copied(input logic [31:0] s, input logic [31:0] d, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (mem[d[11:2] + 10'(i)] !== 32'hA500_0000 + s + 32'(4 * i)) bad++;
    return bad;
  endfunction

  task automatic pulse(input int kind, input int ch);
    @(posedge clk);
    if (kind == 0) sw_trig[ch] <= 1'b1;
    else if (kind == 1) evt_trig[ch] <= 1'b1;
    else per_req[ch] <= 1'b1;
    @(posedge clk);
    sw_trig <= '0; evt_trig <= '0; per_req <= '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int t = 0;
    while (quiet < 6 && t < 5000) begin
      @(negedge clk);
      t++;
      if (!act_valid) quiet++; else quiet = 0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!act_valid, "R11 act_valid after reset", 32'(act_valid), 0);
    chk({fch_valid, dat_rd_valid, dat_wr_valid, wb_valid} == 4'b0, "R11 valids after reset",
        32'({fch_valid, dat_rd_valid, dat_wr_valid, wb_valid}), 0);
    chk(done_pulse == '0, "R11 done after reset", 32'(done_pulse), 0);
  endtask

  task automatic t_single();
    int d0 = done_cnt[2];
    fch_cnt = 0; rd_before_fetch = -1;
    put_desc(32'h120, 3, 32'h400, 32'h800, 0);
    fill(32'h400, 32'h800, 3);
    done_en[2] = 1'b1;
    pulse(0, 2);
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk(flog[k] == 32'h120 + 32'(4 * k), "R3 fetch address order", flog[k], 32'h120 + 32'(4 * k));
    chk(rd_before_fetch == 4, "R3 fetch done before first beat", 32'(rd_before_fetch), 4);
    chk(copied(32'h400, 32'h800, 3) == 0, "R4 single copy data", 32'(copied(32'h400, 32'h800, 3)), 0);
    chk(mem[32'h80C >> 2] == 32'h0, "R5 no beat past count", mem[32'h80C >> 2], 0);
    chk(done_cnt[2] == d0 + 1, "R9 completion pulse with enable", 32'(done_cnt[2]), 32'(d0 + 1));
  endtask

  task automatic t_zero();
    int w0 = wr_cnt;
    int d0 = done_cnt[1];
    put_desc(32'h110, 0, 32'h400, 32'h800, 0);
    done_en[1] = 1'b0;
    pulse(1, 1);
    wait_idle();
    chk(wr_cnt == w0, "R5 zero count gives no beat", 32'(wr_cnt), 32'(w0));
    chk(done_cnt[1] == d0, "R9 no pulse when enable clear", 32'(done_cnt[1]), 32'(d0));
  endtask

  task automatic t_link();
    int d0 = done_cnt[3];
    put_desc(32'h130, 2, 32'h440, 32'h840, 32'h300);
    put_desc(32'h300, 3, 32'h460, 32'h860, 0);
    fill(32'h440, 32'h840, 2);
    fill(32'h460, 32'h860, 3);
    done_en[3] = 1'b1;
    pulse(2, 3);
    wait_idle();
    chk(copied(32'h440, 32'h840, 2) == 0, "R8 first linked block", 32'(copied(32'h440, 32'h840, 2)), 0);
    chk(copied(32'h460, 32'h860, 3) == 0, "R8 second linked block", 32'(copied(32'h460, 32'h860, 3)), 0);
    chk(done_cnt[3] == d0 + 1, "R9 one pulse per chain", 32'(done_cnt[3]), 32'(d0 + 1));
  endtask

  task automatic t_priority();
    int t = 0;
    put_desc(32'h110, 1, 32'h4A0, 32'h8A0, 0);
    put_desc(32'h130, 1, 32'h4B0, 32'h8B0, 0);
    fill(32'h4A0, 32'h8A0, 1);
    fill(32'h4B0, 32'h8B0, 1);
    @(posedge clk);
    evt_trig[1] <= 1'b1; per_req[3] <= 1'b1;
    @(posedge clk);
    evt_trig <= '0; per_req <= '0;
    while (!act_valid && t < 50) begin @(negedge clk); t++; end
    chk(act_valid && act_ch == 2'd1, "R2 lowest index granted first", 32'(act_ch), 1);
    wait_idle();
    chk(copied(32'h4A0, 32'h8A0, 1) == 0, "R1 event trigger served", 32'(copied(32'h4A0, 32'h8A0, 1)), 0);
    chk(copied(32'h4B0, 32'h8B0, 1) == 0, "R1 peripheral trigger served", 32'(copied(32'h4B0, 32'h8B0, 1)), 0);
  endtask

  task automatic t_preempt();
    int w0 = wr_cnt;
    int t = 0;
    logic [31:0] c;
    seen_wb_fetch = 1'b0;
    put_desc(32'h130, 20, 32'h400, 32'h800, 0);
    put_desc(32'h100, 2, 32'h480, 32'h880, 0);
    fill(32'h400, 32'h800, 20);
    fill(32'h480, 32'h880, 2);
    done_en = 4'b1001;
    pulse(0, 3);
    while (wr_cnt < w0 + 5 && t < 500) begin @(negedge clk); t++; end
    pulse(0, 0);
    wait_idle();
    c = mem[32'h230 >> 2];
    chk(c > 0 && c < 20, "R6 saved count mid block", c, 32'hFFFF_FFFF);
    chk(mem[32'h234 >> 2] == 32'h400 + 4 * (20 - c), "R6 saved source", mem[32'h234 >> 2], 32'h400 + 4 * (20 - c));
    chk(mem[32'h238 >> 2] == 32'h800 + 4 * (20 - c), "R6 saved destination", mem[32'h238 >> 2], 32'h800 + 4 * (20 - c));
    chk(mem[32'h23C >> 2] == 32'h0, "R6 saved next word", mem[32'h23C >> 2], 0);
    chk(done_cyc[0] < done_cyc[3], "R6 preempting channel finishes first", 32'(done_cyc[0]), 32'(done_cyc[3]));
    chk(seen_wb_fetch, "R7 resume fetch from save area", 32'(seen_wb_fetch), 1);
    chk(copied(32'h400, 32'h800, 20) == 0, "R7 resumed block complete", 32'(copied(32'h400, 32'h800, 20)), 0);
    chk(copied(32'h480, 32'h880, 2) == 0, "R6 preempting block copied", 32'(copied(32'h480, 32'h880, 2)), 0);
  endtask

  task automatic t_circular();
    int w0 = wr_cnt;
    int d0 = done_cnt[2];
    put_desc(32'h120, 2, 32'h500, 32'h900, 32'h120);
    fill(32'h500, 32'h900, 2);
    done_en[2] = 1'b1;
    pulse(0, 2);
    repeat (80) @(negedge clk);
    chk(wr_cnt - w0 >= 6, "R8 circular link repeats", 32'(wr_cnt - w0), 6);
    chk(done_cnt[2] == d0, "R9 circular chain never ends", 32'(done_cnt[2]), 32'(d0));
    @(posedge clk); rst <= 1'b1;
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    repeat (10) @(negedge clk);
    chk(!act_valid, "R11 reset clears pending channel", 32'(act_valid), 0);
  endtask

  task automatic t_stall();
    put_desc(32'h110, 4, 32'h600, 32'hA00, 0);
    fill(32'h600, 32'hA00, 4);
    proto_err = 0;
    stall = 1'b1;
    pulse(0, 1);
    wait_idle();
    stall = 1'b0;
    chk(copied(32'h600, 32'hA00, 4) == 0, "R4 copy under back-pressure", 32'(copied(32'h600, 32'hA00, 4)), 0);
    chk(proto_err == 0, "R10 single outstanding and hold", 32'(proto_err), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    rst <= 1'b0;
    t_reset();
    t_single();
    t_zero();
    t_link();
    t_priority();
    t_preempt();
    t_circular();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule